// File: doc/BRIEF.md
# Prescaled Serial Baud Generator

This block makes the bit-rate timing for an asynchronous serial controller. A fixed divide-by-four stage runs from the system clock and supplies the counting reference. That reference drives a divider whose ratio comes from an 8-bit baud control register. The register is written over a simple register bus with a write strobe and a data byte, and it can be read back at any time.

The ratio has two parts. The first is a coarse prescaler of 1, 3, 4 or 13. The second is a binary rate divide of 1 to 128. Their product is reported on `divisor_o`. The block emits a single-cycle tick once every 4 × divisor system clocks, so the bit rate is (f_sys / 4) / divisor. Any write to the register restarts the whole chain from zero, and ticks then follow at the new rate. A bootstrap-mode input picks the value the register takes at reset.

Top module: `baud_gen`

## Requirements
- R1: Register bits [5:4] select the prescale factor: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13. `divisor_o` reports that factor times the rate divide.
- R2: Register bits [2:0] hold a value n from 0 to 7 and multiply the prescale factor by 2^n.
- R3: `tick_o` is high for exactly one system clock, once every 4 × `divisor_o` system clocks.
- R4: While `rst_ni` is low with `boot_mode_i` low, the register holds 0x00, `divisor_o` is 1, and the first tick comes 4 clocks after reset is released.
- R5: While `rst_ni` is low with `boot_mode_i` high, the register holds 0x33, `divisor_o` is 104, and the tick period after release is 416 clocks.
- R6: Bits 7, 6 and 3 are stored and read back, but they have no effect on `divisor_o` or on tick timing.
- R7: A write restarts counting at any phase. After the clock edge that samples the write, `tick_o` first rises in the 4 × divisor-th cycle and never before it.
- R8: `reg_rdata_o` and `divisor_o` show a written value from the cycle after the write edge, and they change only on a write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_mode_i | input | 1 | Selects the bootstrap reset value of the register |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current register contents |
| divisor_o | output | 11 | Prescale factor times the rate divide |
| tick_o | output | 1 | One-cycle bit-rate tick |

## Verification
The bench walks through all four prescale codes and several rate exponents, including the slowest setting of 13 × 128. It catches a wrong factor table or a shift by the wrong amount, because in that case the ticks arrive at the wrong cycle. It rewrites the register in the middle of a count. A design that kept its old counter phase would tick early, before the fresh 4 × divisor cycle window, and the bench would see that. It writes values with the test-mode bits set, which exposes any decoding that lets those bits reach the divisor. It also applies reset with and without bootstrap mode, which exposes a wrong reset constant.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned RATE_W  = 3;
  localparam int unsigned PRE_MAX = 13;
  localparam int unsigned DIV_W   = $clog2(PRE_MAX * (1 << ((1 << RATE_W) - 1)) + 1);
  localparam logic [REG_W-1:0] BOOT_VAL = 8'h33;

  typedef struct packed {
    logic              test_hi;
    logic              spare;
    logic [1:0]        pre_sel;
    logic              test_lo;
    logic [RATE_W-1:0] rate_sel;
  } baud_cfg_t;

  function automatic logic [DIV_W-1:0] pre_factor(input logic [1:0] sel);
    case (sel)
      2'b00:   return DIV_W'(1);
      2'b01:   return DIV_W'(3);
      2'b10:   return DIV_W'(4);
      default: return DIV_W'(13);
    endcase
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output baud_cfg_t        cfg_o
);
  baud_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= boot_i ? baud_cfg_t'(BOOT_VAL) : '0;
    else if (we_i) cfg_q <= baud_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/baud_ref_div.sv
module baud_ref_div #(
  parameter int unsigned REF_DIV = 4,
  localparam int unsigned Q_W    = (REF_DIV > 1) ? $clog2(REF_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ref_en_o
);
  logic [Q_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (restart_i) q <= '0;
    else if (ref_en_o)  q <= '0;
    else                q <= q + 1'b1;
  end

  assign ref_en_o = (q == Q_W'(REF_DIV - 1));
endmodule

// File: rtl/baud_rate_cnt.sv
module baud_rate_cnt #(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             ref_en_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;
  logic             last;

  assign last = (cnt == divisor_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt <= '0;
    else if (restart_i) cnt <= '0;
    else if (ref_en_i)  cnt <= last ? '0 : cnt + 1'b1;
  end

  assign tick_o = ref_en_i && last;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned REF_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_mode_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [DIV_W-1:0] divisor_o,
  output logic             tick_o
);
  baud_cfg_t cfg;
  logic      ref_en;

  baud_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .boot_i  (boot_mode_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg)
  );

  // test bits and spare bit are stored only
  always_comb divisor_o = pre_factor(cfg.pre_sel) << cfg.rate_sel;

  assign reg_rdata_o = REG_W'(cfg);

  baud_ref_div #(.REF_DIV(REF_DIV)) u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (reg_we_i),
    .ref_en_o  (ref_en)
  );

  baud_rate_cnt #(.DIV_W(DIV_W)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (reg_we_i),
    .ref_en_i  (ref_en),
    .divisor_i (divisor_o),
    .tick_o    (tick_o)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
  import baud_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic [DIV_W-1:0] divisor_o,
  input logic             tick_o
);
  logic [DIV_W+2:0] gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 gap <= '0;
    else if (reg_we_i || tick_o) gap <= '0;
    else                         gap <= gap + 1'b1;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R3
  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap == {divisor_o, 2'b00} - 1'b1)); // R3
  AST_WRITE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !tick_o); // R7
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ($stable(divisor_o) && $stable(reg_rdata_o))); // R8
  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    divisor_o != '0); // R1
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .divisor_o   (divisor_o),
  .tick_o      (tick_o)
);

// File: tb/baud_gen_tb_top.sv
module baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wd = '0;
  logic [7:0]  rd;
  logic [10:0] div;
  logic        tick;

  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  int   exp_q[$];
  string cur_tag = "R4";

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .boot_mode_i (boot),
    .reg_we_i    (we),
    .reg_wdata_i (wd),
    .reg_rdata_o (rd),
    .divisor_o   (div),
    .tick_o      (tick)
  );

  function automatic int exp_div(input logic [7:0] v);
    int p;
    case (v[5:4])
      2'b00: p = 1;
      2'b01: p = 3;
      2'b10: p = 4;
      default: p = 13;
    endcase
    return p << v[2:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_ticks(input int r, input int d, input int n, input string tag);
    cur_tag = tag;
    for (int i = 1; i <= n; i++) exp_q.push_back(r + 4 * d * i - 1);
  endtask

  // monitor: pops expected tick cycles
  always @(negedge clk) begin
    if (rst_n && tick) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s R7: actual tick at cycle %0d expected none", cur_tag, cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          n_fail++;
          $display("FAIL %s R3: actual tick at cycle %0d expected %0d", cur_tag, cyc, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] v, input int n, input string tag, input bit flush);
    int r;
    if (!flush) wait (exp_q.size() == 0);
    else begin
      repeat (3) @(negedge clk);
      exp_q.delete();
    end
    @(negedge clk);
    we = 1'b1;
    wd = v;
    @(negedge clk);
    we = 1'b0;
    r = cyc;
    check({tag, " R8 rdata"}, int'(rd), int'(v));
    check({tag, " R1 R2 divisor"}, int'(div), exp_div(v));
    push_ticks(r, exp_div(v), n, tag);
  endtask

  task automatic do_reset(input logic b, input logic [7:0] rv, input int n, input string tag);
    int r;
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    boot = b;
    @(negedge clk);
    check({tag, " rdata in reset"}, int'(rd), int'(rv));
    @(negedge clk);
    rst_n = 1'b1;
    r = cyc;
    check({tag, " rdata"}, int'(rd), int'(rv));
    check({tag, " divisor"}, int'(div), exp_div(rv));
    push_ticks(r, exp_div(rv), n, tag);
  endtask

  initial begin
    do_reset(1'b0, 8'h00, 3, "R4");
    wr(8'h00, 3, "R1 sel00", 1'b0);
    wr(8'h10, 3, "R1 sel01", 1'b0);
    wr(8'h20, 3, "R1 sel10", 1'b0);
    wr(8'h30, 2, "R1 sel11", 1'b0);
    wr(8'h01, 2, "R2 n1", 1'b0);
    wr(8'h07, 2, "R2 n7", 1'b0);
    wr(8'h15, 2, "R2 n5", 1'b0);
    wr(8'h37, 1, "R2 slowest", 1'b0);
    wr(8'hDA, 3, "R6 test bits", 1'b0);
    wr(8'h12, 2, "R6 reference", 1'b0);
    wr(8'h03, 2, "R7 pre", 1'b0);
    wr(8'h02, 2, "R7 mid-count", 1'b1);
    wr(8'h00, 2, "R7 mid-count fast", 1'b1);
    do_reset(1'b1, 8'h33, 2, "R5");
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule